// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block sits between a CPU and the flash array and lets the CPU start flash self-programming. Software writes an 8-bit command value into a control register, then fires a store-to-program-memory strobe. The block only honours the command when that strobe arrives within a short window after the register write. If the window expires, the armed command is dropped and its bits clear by themselves.

Two commands exist. A page write passes the page index from the address operand to a flash stub through a start/done handshake. The block then tracks which flash section is being written. A write to the read-while-write section raises a sticky busy flag that blocks reads of that section until software clears it. A write to the other section halts the CPU for the whole operation. A boot lock write clears the stored lock bits selected by zero data bits in a single cycle, and all of flash stays readable meanwhile. A level interrupt is asserted for as long as the interrupt is enabled and no command is pending.

Control register layout:

| Bit | Meaning |
|-----|---------|
| 0 | enable |
| 2 | page-write select |
| 3 | lock-write select |
| 4 | write-only busy release |
| 6 | read-only read-while-write busy |
| 7 | interrupt enable |

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset, `ctrlRdData` is 0, `lockBits` is 4'b1111, and `flashStart`, `rwwBusy`, `cpuHalt` and `irq` are low.
- R2: A control write whose bits 6:0 equal 7'b0000101 arms a page write, and readback shows bits 0 and 2 set. Bits 6:0 equal to 7'b0001001 arm a lock write, and readback shows bits 0 and 3 set. Any other value leaves bits 0, 2 and 3 at zero, and a later strobe starts nothing.
- R3: The strobe is accepted in any of the `WINDOW_CYC` cycles that follow the cycle of the arming write. If no strobe arrives by then, bits 0, 2 and 3 clear, and a later strobe has no effect on `flashStart` or `lockBits`.
- R4: An accepted page-write strobe gives a one-cycle `flashStart` in the next cycle. `flashPage` equals `addrIn[ADDR_W-1:PAGE_OFS_W]`, and `dataIn` has no effect on `lockBits`.
- R5: During a page write, bit 0 stays set until `flashDone` is sampled high in a cycle after `flashStart` was high. Bits 0 and 2 then clear. A `flashDone` that coincides with `flashStart` is ignored.
- R6: A page index below `NRWW_FIRST_PAGE` sets `rwwBusy` (readback bit 6) and keeps `cpuHalt` low. Any other page raises `cpuHalt` from the cycle after the strobe until completion, and leaves `rwwBusy` unchanged.
- R7: On a lock write, each zero in `dataIn[5:2]` clears `lockBits[i-2]`, and each one leaves that bit as it is, so a lock bit never returns to 1. Bit 0 clears in the cycle after the strobe, with no `flashStart` and no `cpuHalt`.
- R8: `rwwBusy` stays set after completion. It clears only on a control write with bit 4 set while no page write is running.
- R9: Bit 7 of each control write sets the interrupt enable. `irq` stays high for every cycle in which that enable is set and bit 0 is clear.
- R10: While a page write runs, control writes change only bit 7. Bits 0, 2 and 3 keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control register write value |
| ctrlRdData | output | 8 | Control register readback |
| storeStrobe | input | 1 | Store-to-program-memory strobe from the CPU |
| addrIn | input | ADDR_W | Byte address operand; the upper bits hold the page index |
| dataIn | input | 8 | Data operand; bits 5:2 drive lock programming |
| flashStart | output | 1 | One-cycle page-write start toward the flash stub |
| flashPage | output | ADDR_W-PAGE_OFS_W | Page index of the running page write |
| flashDone | input | 1 | Completion pulse from the flash stub |
| rwwBusy | output | 1 | Read-while-write section is blocked for reads |
| cpuHalt | output | 1 | CPU halt during a page write outside that section |
| irq | output | 1 | Level interrupt request |
| lockBits | output | 4 | Stored boot lock bits (1 = unprogrammed) |

## Verification
The bench builds the block with `ADDR_W` = 10 and `PAGE_OFS_W` = 4, which gives a 6-bit page index. `NRWW_FIRST_PAGE` is 48, so a few address bits reach pages on both sides of the section boundary. `WINDOW_CYC` keeps its value of 4, so the last accepted strobe position and the first rejected one are both driven exactly. A done pulse that coincides with the start pulse is also driven, to show that it is ignored.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

  // Control register bit positions (software-visible layout)
  localparam int EnBit      = 0;
  localparam int PageSelBit = 2;
  localparam int LockSelBit = 3;
  localparam int RwwRelBit  = 4;
  localparam int RwwBusyBit = 6;
  localparam int IrqEnBit   = 7;

  // Full command patterns on bits 6:0
  localparam logic [6:0] PageCmd = 7'b0000101;
  localparam logic [6:0] LockCmd = 7'b0001001;

  typedef enum logic [1:0] {
    SP_IDLE  = 2'd0,
    SP_ARMED = 2'd1,
    SP_RUN   = 2'd2
  } spState_t;

  // Strobes from sequencer to register datapath
  typedef struct packed {
    logic cmdLoadPage;
    logic cmdLoadLock;
    logic cmdClear;
    logic launchPage;
    logic launchLock;
    logic finish;
    logic rwwClear;
    logic irqLoad;
  } spStrobe_t;

endpackage

// File: rtl/selfprog_seq.sv
module selfprog_seq
  import selfprog_pkg::*;
#(
  parameter int WINDOW_CYC = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctrlWrEn,
  input  logic [6:0] ctrlWrCmd,
  input  logic      storeStrobe,
  input  logic      flashDone,
  output spStrobe_t stb
);

  localparam int CNT_W = $clog2(WINDOW_CYC + 1);
  localparam logic [CNT_W-1:0] LastCnt = CNT_W'(WINDOW_CYC - 1);

  spState_t         state, stateNext;
  logic [CNT_W-1:0] armCnt;
  logic             cmdIsLock;
  logic             firstRun;
  logic             wrPage, wrLock;

  assign wrPage = ctrlWrEn && (ctrlWrCmd == PageCmd);
  assign wrLock = ctrlWrEn && (ctrlWrCmd == LockCmd);

  always_comb begin
    stb          = '0;
    stateNext    = state;
    stb.irqLoad  = ctrlWrEn;
    stb.rwwClear = ctrlWrEn && ctrlWrCmd[RwwRelBit] && (state != SP_RUN);
    unique case (state)
      SP_IDLE: begin
        if (wrPage) begin
          stb.cmdLoadPage = 1'b1;
          stateNext       = SP_ARMED;
        end else if (wrLock) begin
          stb.cmdLoadLock = 1'b1;
          stateNext       = SP_ARMED;
        end else if (ctrlWrEn) begin
          stb.cmdClear = 1'b1;
        end
      end
      SP_ARMED: begin
        if (storeStrobe) begin
          if (cmdIsLock) begin
            stb.launchLock = 1'b1;
            stateNext      = SP_IDLE;
          end else begin
            stb.launchPage = 1'b1;
            stateNext      = SP_RUN;
          end
        end else if (wrPage) begin
          stb.cmdLoadPage = 1'b1;
        end else if (wrLock) begin
          stb.cmdLoadLock = 1'b1;
        end else if (ctrlWrEn || armCnt == LastCnt) begin
          stb.cmdClear = 1'b1;
          stateNext    = SP_IDLE;
        end
      end
      SP_RUN: begin
        if (flashDone && !firstRun) begin
          stb.finish = 1'b1;
          stateNext  = SP_IDLE;
        end
      end
      default: stateNext = SP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SP_IDLE;
      armCnt    <= '0;
      cmdIsLock <= 1'b0;
      firstRun  <= 1'b0;
    end else begin
      state    <= stateNext;
      firstRun <= stb.launchPage;
      if (stb.cmdLoadPage || stb.cmdLoadLock) begin
        armCnt    <= '0;
        cmdIsLock <= stb.cmdLoadLock;
      end else if (state == SP_ARMED) begin
        armCnt <= armCnt + 1'b1;
      end
    end
  end

  // R2
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cmdLoadPage, stb.cmdLoadLock, stb.cmdClear,
              stb.launchPage, stb.launchLock, stb.finish}));

  // R3
  window_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == SP_ARMED) |-> (armCnt <= LastCnt));

  // R5
  no_early_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.launchPage |=> !stb.finish);

endmodule

// File: rtl/selfprog_regs.sv
module selfprog_regs
  import selfprog_pkg::*;
#(
  parameter int PAGE_W          = 9,
  parameter int NRWW_FIRST_PAGE = 448
) (
  input  logic              clk,
  input  logic              rstN,
  input  spStrobe_t         stb,
  input  logic              irqEnIn,
  input  logic [PAGE_W-1:0] pageIn,
  input  logic [3:0]        lockDataIn,
  output logic [7:0]        ctrlRdData,
  output logic              flashStart,
  output logic [PAGE_W-1:0] flashPage,
  output logic              rwwBusy,
  output logic              cpuHalt,
  output logic              irq,
  output logic [3:0]        lockBits
);

  localparam logic [PAGE_W-1:0] NrwwStart = PAGE_W'(NRWW_FIRST_PAGE);

  logic enBit, pageSel, lockSel, irqEn;
  logic runQ, nrwwQ, startQ, rwwQ;
  logic [PAGE_W-1:0] pageQ;
  logic [3:0] lockQ;
  logic pageIsNrww;

  assign pageIsNrww = (pageIn >= NrwwStart);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit   <= 1'b0;
      pageSel <= 1'b0;
      lockSel <= 1'b0;
      irqEn   <= 1'b0;
      runQ    <= 1'b0;
      nrwwQ   <= 1'b0;
      startQ  <= 1'b0;
      rwwQ    <= 1'b0;
      pageQ   <= '0;
      lockQ   <= 4'b1111;
    end else begin
      startQ <= stb.launchPage;
      if (stb.irqLoad) irqEn <= irqEnIn;
      if (stb.cmdLoadPage) begin
        {enBit, pageSel, lockSel} <= 3'b110;
      end else if (stb.cmdLoadLock) begin
        {enBit, pageSel, lockSel} <= 3'b101;
      end else if (stb.cmdClear || stb.launchLock || stb.finish) begin
        {enBit, pageSel, lockSel} <= 3'b000;
      end
      if (stb.rwwClear) rwwQ <= 1'b0;
      if (stb.launchPage) begin
        pageQ <= pageIn;
        nrwwQ <= pageIsNrww;
        runQ  <= 1'b1;
        if (!pageIsNrww) rwwQ <= 1'b1;
      end else if (stb.finish) begin
        runQ <= 1'b0;
      end
      if (stb.launchLock) lockQ <= lockQ & lockDataIn;
    end
  end

  always_comb begin
    ctrlRdData             = '0;
    ctrlRdData[EnBit]      = enBit;
    ctrlRdData[PageSelBit] = pageSel;
    ctrlRdData[LockSelBit] = lockSel;
    ctrlRdData[RwwBusyBit] = rwwQ;
    ctrlRdData[IrqEnBit]   = irqEn;
  end

  assign flashStart = startQ;
  assign flashPage  = pageQ;
  assign rwwBusy    = rwwQ;
  assign cpuHalt    = runQ & nrwwQ;
  assign irq        = irqEn & ~enBit;
  assign lockBits   = lockQ;

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashStart |=> !flashStart);

  // R7
  lock_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((lockBits & ~$past(lockBits)) == 4'b0000));

  // R6
  halt_in_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuHalt |-> (enBit && pageSel));

endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
  import selfprog_pkg::*;
#(
  parameter int ADDR_W          = 17,
  parameter int PAGE_OFS_W      = 8,
  parameter int NRWW_FIRST_PAGE = 448,
  parameter int WINDOW_CYC      = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         ctrlWrEn,
  input  logic [7:0]                   ctrlWrData,
  output logic [7:0]                   ctrlRdData,
  input  logic                         storeStrobe,
  input  logic [ADDR_W-1:0]            addrIn,
  input  logic [7:0]                   dataIn,
  output logic                         flashStart,
  output logic [ADDR_W-PAGE_OFS_W-1:0] flashPage,
  input  logic                         flashDone,
  output logic                         rwwBusy,
  output logic                         cpuHalt,
  output logic                         irq,
  output logic [3:0]                   lockBits
);

  localparam int PAGE_W = ADDR_W - PAGE_OFS_W;

  spStrobe_t stb;
  logic unusedInBits;

  assign unusedInBits = ^{addrIn[PAGE_OFS_W-1:0], dataIn[7:6], dataIn[1:0]};

  selfprog_seq #(
    .WINDOW_CYC(WINDOW_CYC)
  ) u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrCmd  (ctrlWrData[6:0]),
    .storeStrobe(storeStrobe),
    .flashDone  (flashDone),
    .stb        (stb)
  );

  selfprog_regs #(
    .PAGE_W         (PAGE_W),
    .NRWW_FIRST_PAGE(NRWW_FIRST_PAGE)
  ) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .irqEnIn   (ctrlWrData[IrqEnBit]),
    .pageIn    (addrIn[ADDR_W-1:PAGE_OFS_W]),
    .lockDataIn(dataIn[5:2]),
    .ctrlRdData(ctrlRdData),
    .flashStart(flashStart),
    .flashPage (flashPage),
    .rwwBusy   (rwwBusy),
    .cpuHalt   (cpuHalt),
    .irq       (irq),
    .lockBits  (lockBits)
  );

  // R8
  rww_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rwwBusy && !(ctrlWrEn && ctrlWrData[RwwRelBit])) |=> rwwBusy);

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !ctrlRdData[EnBit]);

endmodule

// File: tb/test_selfprog_ctrl.sv
module test_selfprog_ctrl;

  localparam int ADDR_W = 10;
  localparam int OFS_W  = 4;
  localparam int PW     = ADDR_W - OFS_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic [7:0] ctrlRdData;
  logic storeStrobe = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic flashStart;
  logic [PW-1:0] flashPage;
  logic flashDone = 1'b0;
  logic rwwBusy, cpuHalt, irq;
  logic [3:0] lockBits;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  selfprog_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_OFS_W(OFS_W), .NRWW_FIRST_PAGE(48), .WINDOW_CYC(4)
  ) i_selfprog_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .storeStrobe(storeStrobe), .addrIn(addrIn),
    .dataIn(dataIn), .flashStart(flashStart), .flashPage(flashPage),
    .flashDone(flashDone), .rwwBusy(rwwBusy), .cpuHalt(cpuHalt), .irq(irq),
    .lockBits(lockBits)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctrlWrite(input logic [7:0] d);
    ctrlWrEn = 1'b1; ctrlWrData = d;
    @(negedge clk);
    ctrlWrEn = 1'b0; ctrlWrData = '0;
  endtask

  task automatic strobe(input logic [PW-1:0] page, input logic [7:0] d);
    storeStrobe = 1'b1; addrIn = {page, 4'h9}; dataIn = d;
    @(negedge clk);
    storeStrobe = 1'b0; addrIn = '0; dataIn = '0;
  endtask

  task automatic donePulse();
    flashDone = 1'b1;
    @(negedge clk);
    flashDone = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ctrl", 32'(ctrlRdData), 32'h00);
    check("R1 lock", 32'(lockBits), 32'hF);
    check("R1 outs", 32'({flashStart, rwwBusy, cpuHalt, irq}), 32'h0);
  endtask

  task automatic t_page_rww();
    ctrlWrite(8'h05);
    check("R2 page armed", 32'(ctrlRdData), 32'h05);
    idle(2);
    strobe(6'd5, 8'h00);
    check("R4 start", 32'(flashStart), 32'h1);
    check("R4 page", 32'(flashPage), 32'd5);
    check("R4 data ignored", 32'(lockBits), 32'hF);
    check("R6 rww busy", 32'({rwwBusy, ctrlRdData[6], cpuHalt}), 32'b110);
    idle(1);
    check("R4 one pulse", 32'(flashStart), 32'h0);
    check("R5 still enabled", 32'(ctrlRdData[0]), 32'h1);
    donePulse();
    check("R5 cleared", 32'(ctrlRdData[3:0]), 32'h0);
    idle(2);
    check("R8 sticky", 32'(rwwBusy), 32'h1);
    ctrlWrite(8'h10);
    check("R8 release", 32'(rwwBusy), 32'h0);
  endtask

  task automatic t_window();
    ctrlWrite(8'h05);
    idle(3);
    strobe(6'd50, 8'h00);
    check("R3 last slot", 32'(flashStart), 32'h1);
    idle(1);
    donePulse();
    ctrlWrite(8'h05);
    idle(4);
    check("R3 auto clear", 32'(ctrlRdData), 32'h00);
    strobe(6'd50, 8'h00);
    check("R3 late page", 32'(flashStart), 32'h0);
    ctrlWrite(8'h09);
    idle(4);
    strobe(6'd0, 8'h00);
    check("R3 late lock", 32'(lockBits), 32'hF);
  endtask

  task automatic t_nrww();
    ctrlWrite(8'h05);
    flashDone = 1'b1;
    strobe(6'd50, 8'h00);
    check("R6 halt", 32'({cpuHalt, rwwBusy}), 32'b10);
    donePulse();
    check("R5 done with start ignored", 32'(ctrlRdData[0]), 32'h1);
    idle(2);
    check("R6 halt held", 32'(cpuHalt), 32'h1);
    donePulse();
    check("R6 halt released", 32'(cpuHalt), 32'h0);
    check("R5 nrww clear", 32'(ctrlRdData[3:0]), 32'h0);
  endtask

  task automatic t_lock();
    ctrlWrite(8'h09);
    check("R2 lock armed", 32'(ctrlRdData), 32'h09);
    idle(1);
    strobe(6'd33, 8'hEB);
    check("R7 program", 32'(lockBits), 32'b1010);
    check("R7 enable clear", 32'(ctrlRdData[3:0]), 32'h0);
    check("R7 no start", 32'({flashStart, cpuHalt, rwwBusy}), 32'h0);
    ctrlWrite(8'h09);
    strobe(6'd7, 8'hFF);
    check("R7 no return to 1", 32'(lockBits), 32'b1010);
  endtask

  task automatic t_invalid();
    ctrlWrite(8'h07);
    check("R2 bad pattern", 32'(ctrlRdData), 32'h00);
    ctrlWrite(8'h25);
    check("R2 extra bit", 32'(ctrlRdData), 32'h00);
    strobe(6'd3, 8'h00);
    check("R2 no start", 32'({flashStart, lockBits}), 32'h0A);
  endtask

  task automatic t_irq_run();
    ctrlWrite(8'h80);
    check("R9 irq idle", 32'({irq, ctrlRdData}), 32'h180);
    ctrlWrite(8'h85);
    check("R9 irq armed low", 32'(irq), 32'h0);
    strobe(6'd2, 8'h00);
    ctrlWrite(8'h90);
    check("R8 no release in run", 32'(rwwBusy), 32'h1);
    check("R10 cmd bits kept", 32'(ctrlRdData[3:0]), 32'h5);
    ctrlWrite(8'h09);
    check("R10 only bit7", 32'(ctrlRdData), 32'h45);
    ctrlWrite(8'h80);
    check("R9 irq in run", 32'(irq), 32'h0);
    donePulse();
    check("R9 irq after done", 32'(irq), 32'h1);
    idle(3);
    check("R9 irq level", 32'(irq), 32'h1);
    ctrlWrite(8'h90);
    check("R8 release idle", 32'({rwwBusy, irq}), 32'b01);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    t_reset();
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_page_rww();
    t_window();
    t_nrww();
    t_lock();
    t_invalid();
    t_irq_run();
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule